// File: doc/BRIEF.md
# Packed Widening Multiply-Accumulate Unit

This block is a SIMD datapath slice. It takes two packed source words of `SRC_W` bits (64 by default) and one packed accumulator word twice as wide. The source words are cut into lanes of 8, 16 or 32 bits, chosen per operation. In every lane the two source elements are multiplied, and the full-width product is added to or subtracted from the matching double-width accumulator lane. The lanes of the result are packed into a destination word as wide as the accumulator.

Each operation also carries a signedness control and the least-significant bit of the destination register index. The lane width code 11 and an odd destination index are illegal. An illegal operation raises a flag and returns the accumulator word unchanged. Every operation takes exactly one clock cycle from a valid input to a valid output, whatever its mode or data, so execution time does not depend on operand values.

Top module: `wmac_unit`

## Requirements
- R1: `size_code` selects the element width: 00 gives 8 bits, 01 gives 16 bits, 10 gives 32 bits. There are `SRC_W`/width lanes. Source lane e occupies bits [e*w +: w] (lane 0 in the least significant bits). Destination and accumulator lane e occupies bits [e*2w +: 2w].
- R2: When `is_unsigned` is 1, both source elements are treated as unsigned integers.
- R3: When `is_unsigned` is 0, both source elements are treated as signed two's complement and are sign-extended before the multiply.
- R4: When `do_sub` is 0, the product is added to the accumulator lane. When `do_sub` is 1, the product is subtracted from it.
- R5: Each lane result wraps modulo 2^(2w). No carry or borrow crosses into a neighbouring lane.
- R6: A valid operation with `size_code` 11 sets `illegal` to 1 and makes `result` equal to that operation's `acc_in`.
- R7: A valid operation with `dst_idx_lsb` = 1 sets `illegal` to 1 and makes `result` equal to that operation's `acc_in`. A legal operation clears `illegal`.
- R8: `out_valid` is asserted in the cycle right after each cycle with `in_valid` high, and not otherwise. The latency is the same for every size, mode and data value.
- R9: When `in_valid` is low, `result` and `illegal` hold their values whatever the other inputs do.
- R10: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| size_code | input | 2 | Element width code (00 = 8, 01 = 16, 10 = 32, 11 = illegal) |
| is_unsigned | input | 1 | 1 = unsigned sources, 0 = signed sources |
| do_sub | input | 1 | 0 = accumulate the product, 1 = subtract the product |
| dst_idx_lsb | input | 1 | Least-significant bit of the destination register index; 1 = illegal |
| src_a | input | SRC_W | First packed source |
| src_b | input | SRC_W | Second packed source |
| acc_in | input | 2*SRC_W | Packed double-width accumulator |
| out_valid | output | 1 | Result present, one cycle after `in_valid` |
| result | output | 2*SRC_W | Packed destination |
| illegal | output | 1 | Operation was illegal; `result` carries `acc_in` unchanged |

## Verification
The bench builds the unit with the default `SRC_W` of 64. With that width there are 8, 4 and 2 lanes, and a 32-bit lane accumulates into a full 64-bit field, which lets the reference model work on plain 64-bit arithmetic with no wider intermediate. At this width, hand-picked vectors reach the extreme operands: 0xFF times 0xFF, the most negative 32-bit value squared, and an accumulator lane of all ones that wraps to zero. A random sweep over all twelve combinations of size, signedness and direction then compares every lane against the bench's own model.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

   // number of legal element widths (8, 16, 32)
   localparam int NUM_SIZES = 3;

   typedef enum logic [1:0] {
      SZ_B8  = 2'b00,
      SZ_B16 = 2'b01,
      SZ_B32 = 2'b10,
      SZ_BAD = 2'b11
   } esize_e;

   // element width in bits for a legal size code
   function automatic int lane_bits(input int code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/wmac_lane.sv
// One lane: widening multiply then modular add/subtract into a 2*EW accumulator.
module wmac_lane #(
   parameter int EW = 8
) (
   input  logic [EW-1:0]   a,
   input  logic [EW-1:0]   b,
   input  logic [2*EW-1:0] acc,
   input  logic            is_uns,
   input  logic            do_sub,
   output logic [2*EW-1:0] res
);
   localparam int AW = 2 * EW;

   logic            a_top;
   logic            b_top;
   logic signed [AW-1:0] a_x;
   logic signed [AW-1:0] b_x;
   logic signed [AW-1:0] prod;
   logic [AW-1:0]   p_lo;

   always_comb begin
      // extension bit: sign for signed lanes, zero for unsigned lanes
      a_top = ~is_uns & a[EW-1];
      b_top = ~is_uns & b[EW-1];
      a_x   = {{EW{a_top}}, a};
      b_x   = {{EW{b_top}}, b};
      // low AW bits of the product are exact for both interpretations
      prod  = a_x * b_x;
      p_lo  = prod;
      res   = do_sub ? (acc - p_lo) : (acc + p_lo);
   end

endmodule

// File: rtl/wmac_bank.sv
// All lanes for one fixed element width.
module wmac_bank #(
   parameter int SRC_W = 64,
   parameter int EW    = 8
) (
   input  logic [SRC_W-1:0]   a,
   input  logic [SRC_W-1:0]   b,
   input  logic [2*SRC_W-1:0] acc,
   input  logic               is_uns,
   input  logic               do_sub,
   output logic [2*SRC_W-1:0] res
);
   localparam int NL = SRC_W / EW;
   localparam int AW = 2 * EW;

   if (SRC_W % EW != 0) begin : g_bad_width
      $error("wmac_bank: SRC_W must be a multiple of EW");
   end

   for (genvar l = 0; l < NL; l++) begin : g_lane
      wmac_lane #(.EW(EW)) u_lane (
         .a      (a[l*EW +: EW]),
         .b      (b[l*EW +: EW]),
         .acc    (acc[l*AW +: AW]),
         .is_uns (is_uns),
         .do_sub (do_sub),
         .res    (res[l*AW +: AW])
      );
   end

endmodule

// File: rtl/wmac_ctrl.sv
// Control decode: legality and bank selection.
module wmac_ctrl (
   input  logic [1:0] size_code,
   input  logic       dst_idx_lsb,
   output logic       bad_op,
   output logic [1:0] bank_sel
);
   import wmac_pkg::*;

   always_comb begin
      bad_op   = (esize_e'(size_code) == SZ_BAD) | dst_idx_lsb;
      bank_sel = size_code;
   end

endmodule

// File: rtl/wmac_unit.sv
// Packed widening multiply-accumulate, one registered cycle of latency.
module wmac_unit #(
   parameter int SRC_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         size_code,
   input  logic               is_unsigned,
   input  logic               do_sub,
   input  logic               dst_idx_lsb,
   input  logic [SRC_W-1:0]   src_a,
   input  logic [SRC_W-1:0]   src_b,
   input  logic [2*SRC_W-1:0] acc_in,
   output logic               out_valid,
   output logic [2*SRC_W-1:0] result,
   output logic               illegal
);
   import wmac_pkg::*;

   localparam int DW = 2 * SRC_W;

   if (SRC_W < 32 || SRC_W % 32 != 0) begin : g_bad_src
      $error("wmac_unit: SRC_W must be a positive multiple of 32");
   end

   logic [DW-1:0] bank_res [NUM_SIZES];
   logic [DW-1:0] res_d;
   logic          bad_op;
   logic [1:0]    bank_sel;

   wmac_ctrl u_ctrl (
      .size_code   (size_code),
      .dst_idx_lsb (dst_idx_lsb),
      .bad_op      (bad_op),
      .bank_sel    (bank_sel)
   );

   // one bank per legal element width, every bank evaluated every cycle
   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
      wmac_bank #(.SRC_W(SRC_W), .EW(lane_bits(s))) u_bank (
         .a      (src_a),
         .b      (src_b),
         .acc    (acc_in),
         .is_uns (is_unsigned),
         .do_sub (do_sub),
         .res    (bank_res[s])
      );
   end

   always_comb begin
      if (bad_op) begin
         res_d = acc_in;
      end else begin
         case (bank_sel)
            2'd0:    res_d = bank_res[0];
            2'd1:    res_d = bank_res[1];
            2'd2:    res_d = bank_res[2];
            default: res_d = acc_in;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= res_d;
            illegal <= bad_op;
         end
      end
   end

endmodule

// File: rtl/wmac_unit_chk.sv
// Property checker bound to wmac_unit.
module wmac_unit_chk #(
   parameter int SRC_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [1:0]         size_code,
   input logic               dst_idx_lsb,
   input logic [2*SRC_W-1:0] acc_in,
   input logic               out_valid,
   input logic [2*SRC_W-1:0] result,
   input logic               illegal
);

   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_bad_size_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code == 2'b11) |=> (illegal && result == $past(acc_in)));

   assert_odd_dest_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_idx_lsb) |=> (illegal && result == $past(acc_in)));

   assert_legal_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_code != 2'b11 && !dst_idx_lsb) |=> !illegal);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(illegal)));

endmodule

bind wmac_unit wmac_unit_chk #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/wmac_unit_tb.sv
`timescale 1ns/1ps
module wmac_unit_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   size_code = 2'b00;
   logic         is_unsigned = 1'b0;
   logic         do_sub = 1'b0;
   logic         dst_idx_lsb = 1'b0;
   logic [63:0]  src_a = '0;
   logic [63:0]  src_b = '0;
   logic [127:0] acc_in = '0;
   logic         out_valid;
   logic [127:0] result;
   logic         illegal;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   wmac_unit #(.SRC_W(64)) u_dut (.*);

   typedef struct packed {
      logic [1:0]   sz;
      logic         u;
      logic         s;
      logic [63:0]  a;
      logic [63:0]  b;
      logic [127:0] acc;
      logic [127:0] exp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VT [NV] = '{
      // R2 R1: 8-bit unsigned 0xFF*0xFF into lane 0
      '{2'b00, 1'b1, 1'b0, 64'hFF, 64'hFF, 128'h0, 128'hFE01},
      // R3: 8-bit signed -1*-1 = 1
      '{2'b00, 1'b0, 1'b0, 64'hFF, 64'hFF, 128'h0, 128'h0001},
      // R3 R4: 16-bit signed 0 - (-1*2) = 2
      '{2'b01, 1'b0, 1'b1, 64'hFFFF, 64'h0002, 128'h0, 128'h2},
      // R5: lane 0 wraps to zero, lane 1 untouched
      '{2'b00, 1'b1, 1'b0, 64'h01, 64'h01, 128'hFFFF, 128'h0},
      // R1 R2: 32-bit unsigned in lane 1
      '{2'b10, 1'b1, 1'b0, 64'hFFFFFFFF_00000000, 64'hFFFFFFFF_00000000,
        128'h0, {64'hFFFFFFFE_00000001, 64'h0}},
      // R3 R4: 32-bit signed, 0 - (-2^31)^2
      '{2'b10, 1'b0, 1'b1, 64'h80000000, 64'h80000000, 128'h0,
        128'hC0000000_00000000},
      // R4 R1: 16-bit unsigned subtract in lane 3
      '{2'b01, 1'b1, 1'b1, 64'h0003_0000_0000_0000, 64'h0004_0000_0000_0000,
        {32'h10, 96'h0}, {32'h4, 96'h0}}
   };

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // drive one operation on a falling edge; outputs are checked at the next falling edge
   task automatic issue(input logic [1:0] sz, input logic u, input logic s, input logic odd,
                        input logic [63:0] a, input logic [63:0] b, input logic [127:0] acc);
      @(negedge clk);
      in_valid = 1'b1; size_code = sz; is_unsigned = u; do_sub = s;
      dst_idx_lsb = odd; src_a = a; src_b = b; acc_in = acc;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [127:0] ref_model(input int sz, input bit u, input bit s,
                                               input logic [63:0] a, input logic [63:0] b,
                                               input logic [127:0] acc);
      int ew = 8 << sz;
      int n = 64 / ew;
      logic [63:0] m1 = (64'd1 << ew) - 64'd1;
      logic [63:0] m2 = (ew == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2*ew)) - 64'd1);
      logic [127:0] r = '0;
      for (int e = 0; e < n; e++) begin
         logic [63:0] ae, be, ac, p;
         ae = (a >> (e*ew)) & m1;
         be = (b >> (e*ew)) & m1;
         if (!u && ae[ew-1]) ae = ae | ~m1;
         if (!u && be[ew-1]) be = be | ~m1;
         p  = ae * be;
         ac = 64'(acc >> (e*2*ew)) & m2;
         ac = s ? (ac - p) : (ac + p);
         r  = r | (128'(ac & m2) << (e*2*ew));
      end
      return r;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R8 act=hung exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 out_valid", 128'(out_valid), 128'h0);
      check("R10 result", result, 128'h0);
      check("R10 illegal", 128'(illegal), 128'h0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         issue(VT[i].sz, VT[i].u, VT[i].s, 1'b0, VT[i].a, VT[i].b, VT[i].acc);
         check($sformatf("R1-table vec %0d result", i), result, VT[i].exp);
         check($sformatf("R8 vec %0d out_valid", i), 128'(out_valid), 128'h1);
         check($sformatf("R7 vec %0d legal illegal", i), 128'(illegal), 128'h0);
      end

      // R8: no valid when idle
      @(negedge clk);
      check("R8 idle out_valid", 128'(out_valid), 128'h0);

      // R9: idle with changed inputs holds result
      issue(2'b00, 1'b1, 1'b0, 1'b0, 64'h02, 64'h03, 128'h0);
      check("R9 setup", result, 128'h6);
      src_a = '1; src_b = '1; acc_in = '1; size_code = 2'b11; dst_idx_lsb = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R9 result held", result, 128'h6);
      check("R9 illegal held", 128'(illegal), 128'h0);
      check("R9 out_valid low", 128'(out_valid), 128'h0);

      // R6: size code 11
      issue(2'b11, 1'b0, 1'b0, 1'b0, 64'h1234, 64'h5678, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
      check("R6 result passthrough", result, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
      check("R6 illegal", 128'(illegal), 128'h1);
      check("R6 out_valid", 128'(out_valid), 128'h1);

      // R7: odd destination index
      issue(2'b01, 1'b1, 1'b1, 1'b1, 64'hFFFF, 64'hFFFF, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
      check("R7 result passthrough", result, 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677);
      check("R7 illegal", 128'(illegal), 128'h1);

      // R7: legal op clears flag
      issue(2'b10, 1'b1, 1'b0, 1'b0, 64'h2, 64'h3, 128'h0);
      check("R7 flag cleared", 128'(illegal), 128'h0);
      check("R7 legal result", result, 128'h6);

      // R1 R2 R3 R4 R5: random sweep over every mode
      for (int sz = 0; sz < 3; sz++) begin
         for (int u = 0; u < 2; u++) begin
            for (int s = 0; s < 2; s++) begin
               for (int k = 0; k < 20; k++) begin
                  logic [63:0]  ra, rb;
                  logic [127:0] racc;
                  ra   = {$urandom, $urandom};
                  rb   = {$urandom, $urandom};
                  racc = {$urandom, $urandom, $urandom, $urandom};
                  issue(2'(sz), 1'(u), 1'(s), 1'b0, ra, rb, racc);
                  check($sformatf("R5 random sz=%0d u=%0d sub=%0d", sz, u, s), result,
                        ref_model(sz, 1'(u), 1'(s), ra, rb, racc));
               end
            end
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule